// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiply-Accumulate Unit

This block multiplies two W-bit operands over several clock cycles and returns the low W bits of the product. An optional addend can be folded in, which gives a multiply-accumulate. Each cycle it retires two multiplier bits. A small recoder looks at those two bits and at a one-bit pending correction. From these it picks one of three actions on the multiplicand: add it, subtract it, or skip it. It also picks a shift of one or two times, and it produces the correction carried into the next cycle. The accumulator starts at zero for a plain multiply, or at the addend when accumulation is requested.

The iteration ends early once the unconsumed multiplier bits are all zero and no correction is pending. Small multipliers therefore finish in a few cycles. The worst case is W/2 cycles. A controller sequences the states. ST_IDLE waits for `start`; the transition "launch" loads the operands. ST_RUN performs one recoded step per cycle; it leaves through "finish" when the step is the last one, and otherwise "iterate" keeps it there. ST_DONE raises `done` for a single cycle, and the transition "retire" returns to ST_IDLE.

A client pulses `start` with the operands present, waits for `done`, and then reads `product`. The product stays valid until the next operation completes.

Top module: `booth_mac`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: With `accum_en`=0, the result is (`mcand_in` × `mplier_in`) mod 2^W.
- R3: With `accum_en`=1, the result is (`mcand_in` × `mplier_in` + `addend_in`) mod 2^W.
- R4: `busy` is high for k cycles, where k is the smallest value from 1 to W/2 with `mplier_in` < 2^(2k−1). When no such k exists, k = W/2.
- R5: A multiplier with every bit set, or with its top bit set, takes the full W/2 cycles and still gives the correct low product bits.
- R6: `done` is high for exactly one cycle, in the cycle right after the last `busy` cycle. `product` changes only at that point and otherwise holds its value.
- R7: A `start` pulse while `busy` is high is ignored. The running operation's result and latency are unaffected, and the operands presented with that pulse are never used.
- R8: A zero multiplier completes in one cycle and returns the addend (R3 case) or 0.
- R9: Operands are treated as two's-complement or unsigned alike. Negative operands yield the same low W bits as the unsigned product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled in ST_IDLE |
| accum_en | input | 1 | Seed the accumulator with the addend |
| mcand_in | input | W | Multiplicand |
| mplier_in | input | W | Multiplier |
| addend_in | input | W | Accumulate operand |
| busy | output | 1 | High in ST_RUN |
| done | output | 1 | One-cycle completion pulse |
| product | output | W | Low W bits of the result |

## Verification
The bench builds the block with its default width of 32, so the step cap is 16. With that cap, an all-ones multiplier and a multiplier with only the top bit set both reach the full iteration count. Small multipliers such as 1, 2 and 5 show early exit after one or two cycles. A scoreboard predicts both the product and the busy-cycle count for each operation. These include a second launch attempted in the middle of a long operation.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        OP_SKIP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } op_t;

    typedef struct packed {
        op_t  op;
        logic dbl;   // apply the multiplicand shifted one extra place
        logic cout;  // correction passed to the next pair
    } step_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic       cin,
    input  logic [1:0] pair,
    output step_t      step
);

    always_comb begin
        step = '{op: OP_SKIP, dbl: 1'b0, cout: 1'b0};
        unique case ({cin, pair})
            3'b000: step = '{op: OP_SKIP, dbl: 1'b0, cout: 1'b0};
            3'b001: step = '{op: OP_ADD,  dbl: 1'b0, cout: 1'b0};
            3'b010: step = '{op: OP_SUB,  dbl: 1'b1, cout: 1'b1};
            3'b011: step = '{op: OP_SUB,  dbl: 1'b0, cout: 1'b1};
            3'b100: step = '{op: OP_ADD,  dbl: 1'b0, cout: 1'b0};
            3'b101: step = '{op: OP_ADD,  dbl: 1'b1, cout: 1'b0};
            3'b110: step = '{op: OP_SUB,  dbl: 1'b0, cout: 1'b1};
            3'b111: step = '{op: OP_SKIP, dbl: 1'b0, cout: 1'b1};
            default: step = '{op: OP_SKIP, dbl: 1'b0, cout: 1'b0};
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  step_t        step,
    output logic [W-1:0] acc_next
);

    logic [W-1:0] term;

    always_comb begin
        term = step.dbl ? {mcand[W-2:0], 1'b0} : mcand;
        unique case (step.op)
            OP_ADD:  acc_next = acc + term;
            OP_SUB:  acc_next = acc - term;
            default: acc_next = acc;
        endcase
    end

endmodule

// File: rtl/booth_fsm.sv
module booth_fsm
    import booth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);

    state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;   // launch
            ST_RUN:  if (last)  state_nx = ST_DONE;  // finish, else iterate
            ST_DONE: state_nx = ST_IDLE;             // retire
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_RUN: begin
                step_en = 1'b1;
                busy    = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/booth_mac.sv
module booth_mac
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         accum_en,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    input  logic [W-1:0] addend_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] product
);

    localparam int STEPS = W / 2;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [W-1:0]  acc_q, mcand_q, mreg_q, acc_next;
    logic          carry_q;
    logic [CW-1:0] cnt_q;
    logic          load, step_en, last;
    step_t         step;

    booth_recode u_rec (
        .cin  (carry_q),
        .pair (mreg_q[1:0]),
        .step (step)
    );

    booth_addsub #(.W(W)) u_add (
        .acc      (acc_q),
        .mcand    (mcand_q),
        .step     (step),
        .acc_next (acc_next)
    );

    assign last = ((mreg_q[W-1:2] == '0) && !step.cout) || (cnt_q == CW'(STEPS - 1));

    booth_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .last    (last),
        .load    (load),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
            mreg_q  <= '0;
            carry_q <= 1'b0;
            cnt_q   <= '0;
            product <= '0;
        end else if (load) begin
            acc_q   <= accum_en ? addend_in : '0;
            mcand_q <= mcand_in;
            mreg_q  <= mplier_in;
            carry_q <= 1'b0;
            cnt_q   <= '0;
        end else if (step_en) begin
            acc_q   <= acc_next;
            mcand_q <= {mcand_q[W-3:0], 2'b00};
            mreg_q  <= {2'b00, mreg_q[W-1:2]};
            carry_q <= step.cout;
            cnt_q   <= cnt_q + 1'b1;
            if (last) product <= acc_next;
        end
    end

endmodule

// File: rtl/booth_mac_chk.sv
module booth_mac_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] product
);

    localparam int STEPS = W / 2;

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(product));

    // R4
    busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < STEPS));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind booth_mac booth_mac_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/sim_booth_mac.sv
`timescale 1ns/1ps
module sim_booth_mac;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         accum_en = 1'b0;
    logic [W-1:0] mcand_in = '0;
    logic [W-1:0] mplier_in = '0;
    logic [W-1:0] addend_in = '0;
    logic         busy, done;
    logic [W-1:0] product;

    always #10 clk = ~clk;

    booth_mac #(.W(W)) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .accum_en (accum_en),
        .mcand_in (mcand_in), .mplier_in (mplier_in), .addend_in (addend_in),
        .busy (busy), .done (done), .product (product)
    );

    typedef struct {
        logic [W-1:0] prod;
        int           lat;
        string        tag;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    int issued   = 0;
    int seen     = 0;
    int run_cnt  = 0;
    bit finished = 0;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // R4: smallest k in 1..W/2 with m < 2^(2k-1), else W/2
    function automatic int exp_lat(input logic [W-1:0] m);
        int k = 1;
        while (k < W / 2 && ((64'(m) >> (2 * k - 1)) != 0)) k++;
        return k;
    endfunction

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic acc, input logic [W-1:0] c,
                          input string tag, input bit disturb);
        exp_t e;
        e.prod = W'(a * b + (acc ? c : '0));
        e.lat  = exp_lat(b);
        e.tag  = tag;
        q.push_back(e);
        issued++;
        @(negedge clk);
        mcand_in = a; mplier_in = b; accum_en = acc; addend_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            @(negedge clk);
            mcand_in = 32'h0BAD_F00D; mplier_in = 32'h3; accum_en = 1'b1;
            addend_in = 32'h1111_1111; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (seen < issued) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) run_cnt++;
            if (done) begin
                exp_t e;
                if (q.size() == 0) begin
                    check("R6 unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    check({e.tag, " product"}, product, e.prod);
                    check("R4 latency", run_cnt, e.lat);
                end
                run_cnt = 0;
                seen++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 product", product, 0);

        run_op(32'd3, 32'd5, 1'b0, '0, "R2 small", 0);
        run_op(32'd77, 32'd1, 1'b0, '0, "R2 mult one", 0);
        run_op(32'd77, 32'd2, 1'b0, '0, "R2 mult two", 0);
        run_op(32'd9, 32'd0, 1'b1, 32'd1234, "R8 zero mult accum", 0);
        run_op(32'd9, 32'd0, 1'b0, 32'd1234, "R8 zero mult plain", 0);
        run_op(32'd7, 32'hFFFF_FFFF, 1'b0, '0, "R5 all ones", 0);
        run_op(32'h1234_5679, 32'h8000_0000, 1'b0, '0, "R5 top bit", 0);
        run_op(32'hFFFF_FFFD, 32'd1000, 1'b0, '0, "R9 negative mcand", 0);
        run_op(32'hFFFF_FF85, 32'hFFFF_FFF0, 1'b0, '0, "R9 both negative", 0);
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 32'hDEAD_BEEF, "R3 accumulate", 0);
        run_op(32'd0, 32'h0000_FFFF, 1'b0, '0, "R2 zero mcand", 0);
        run_op(32'hCAFE_0001, 32'hFFFF_FFFF, 1'b1, 32'd5, "R7 start while busy", 1);
        check("R6 product held", product, 32'(32'hCAFE_0001 * 32'hFFFF_FFFF + 32'd5));

        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] a, b, c;
            a = $urandom; b = $urandom >> (i % 32); c = $urandom;
            run_op(a, b, i[0], c, (i[0] ? "R3 random" : "R2 random"), 0);
        end

        repeat (2) @(negedge clk);
        report();
    end

endmodule